// File: doc/BRIEF.md
# Debounced Wake-Pin SMI Controller

This block watches three general-purpose wake pins and turns a qualified activation on any of them into a system management interrupt request. Software configures it over a small byte-wide register port. Each pin has its own polarity select and its own direction select. An input pin's level crosses a two-flop synchroniser and is then corrected for polarity. It must hold steady for a fixed debounce interval before the block treats it as a new level.

When a debounced, polarity-corrected level moves from inactive to active, the pin must also be an input and be enabled. The enable is either the pin's own SMI enable bit or a competing enable arriving from elsewhere in the chip, and the local bit overrides the competing one whenever it is set. All three pins share one sticky status flag. The flag drives the interrupt request directly and stays set until software writes a one to clear it.

The debounce interval is the parameter `DEBOUNCE_CYCLES`, which is the 31 µs requirement multiplied by the clock frequency and rounded up. The default of 31 suits a 1 MHz clock.

Top module: `wakeSmiTop`

## Requirements
- R1: After reset, reads at addresses 0, 1 and 2 return 00h and `smiReq` is 0, so every pin starts as an active-high input with its enable clear.
- R2: Address 0 is the polarity register. Bit n selects the polarity of pin n (0 means active high, 1 means active low). A read returns the last written bits 2:0 and returns 0 in bits 7:3.
- R3: Address 1 is the configuration register. Bits 6:4 are the SMI enables for pins 0 to 2. Bits 2:0 are the directions for pins 0 to 2 (0 means input, 1 means output). A read returns 0 in bits 7 and 3 whatever was written there.
- R4: A change on a pin input passes two synchroniser stages and then must persist for `DEBOUNCE_CYCLES` clocks. For a qualifying activation, `smiReq` is 0 after the (`DEBOUNCE_CYCLES`+1)th rising edge that follows the change and is 1 after the (`DEBOUNCE_CYCLES`+2)th.
- R5: A corrected level that returns to its debounced value before the interval expires restarts the count and raises nothing.
- R6: A pin with its polarity bit at 1 raises the SMI on a high-to-low change.
- R7: A pin whose direction bit is 1 (output) never raises the SMI, even with its enable set.
- R8: A pin is enabled when its own SMI enable bit is 1 or its bit of `altEnable` is 1. With both at 0 it raises nothing.
- R9: The shared status flag is read at address 2, bit 0. Writing 1 to that bit clears it on the next edge. Writing 0 leaves it unchanged.
- R10: When a qualifying activation and a clearing write fall on the same edge, the flag ends up set.
- R11: Only an inactive-to-active debounced change raises the SMI. An active-to-inactive change does not.
- R12: `smiReq` always equals the status flag. Address 3 reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Write strobe for the register port |
| regAddr | input | 2 | Register address, used for both read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| pinIn | input | 3 | Raw asynchronous wake pin levels |
| altEnable | input | 3 | Competing per-pin SMI enable from elsewhere |
| smiReq | output | 1 | Active-high SMI request |

## Verification
The status flag can be set by a debounced activation and cleared by a software write on the same clock edge, and the result must be that the flag stays set. The bench provokes this by setting the flag first and then starting a second pin's activation. It counts edges so that a write-one-to-clear lands exactly on the edge where that activation completes its debounce. It judges the outcome by reading `smiReq` just after that edge and again after a later plain clear. Every cycle the request and the read data are also compared against a behavioural model of the synchroniser, debounce and flag.

// File: rtl/wakeSmiPkg.sv
package wakeSmiPkg;
  localparam int PIN_COUNT = 3;

  localparam logic [1:0] ADDR_POL  = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic polWr;
    logic cfgWr;
    logic statClr;
  } ctrlStrobe_t;
endpackage

// File: rtl/wakeSmiDebounce.sv
module wakeSmiDebounce #(
  parameter int DEBOUNCE_CYCLES = 31
) (
  input  logic clk,
  input  logic rstN,
  input  logic levelIn,
  output logic levelOut,
  output logic riseNow
);
  localparam int CNT_W = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

  logic [CNT_W-1:0] holdCnt;
  logic             stableLvl;
  logic             expire;

  assign expire = (levelIn != stableLvl) && (holdCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt   <= '0;
      stableLvl <= 1'b0;
    end else if (levelIn == stableLvl) begin
      holdCnt <= '0;
    end else if (holdCnt == CNT_LAST) begin
      stableLvl <= levelIn;
      holdCnt   <= '0;
    end else begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign levelOut = stableLvl;
  assign riseNow  = expire && levelIn;
endmodule

// File: rtl/wakeSmiCtrl.sv
module wakeSmiCtrl
  import wakeSmiPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regAddr,
  input  logic        clrBit,
  input  logic        anyHit,
  output ctrlStrobe_t strobe,
  output logic        statusBit
);
  always_comb begin
    strobe.polWr   = regWr && (regAddr == ADDR_POL);
    strobe.cfgWr   = regWr && (regAddr == ADDR_CFG);
    strobe.statClr = regWr && (regAddr == ADDR_STAT) && clrBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusBit <= 1'b0;
    end else if (anyHit) begin
      statusBit <= 1'b1;
    end else if (strobe.statClr) begin
      statusBit <= 1'b0;
    end
  end
endmodule

// File: rtl/wakeSmiDatapath.sv
module wakeSmiDatapath
  import wakeSmiPkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 31
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [PIN_COUNT-1:0] polData,
  input  logic [PIN_COUNT-1:0] enData,
  input  logic [PIN_COUNT-1:0] dirData,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [PIN_COUNT-1:0] altEnable,
  input  logic [1:0]           regAddr,
  input  logic                 statusBit,
  output logic [7:0]           rdData,
  output logic [PIN_COUNT-1:0] hitVec,
  output logic [PIN_COUNT-1:0] corrVec
);
  logic [PIN_COUNT-1:0] polReg;
  logic [PIN_COUNT-1:0] enReg;
  logic [PIN_COUNT-1:0] dirReg;
  logic [PIN_COUNT-1:0] syncA;
  logic [PIN_COUNT-1:0] syncB;
  logic [PIN_COUNT-1:0] riseVec;
  logic [PIN_COUNT-1:0] dbVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polReg <= '0;
      enReg  <= '0;
      dirReg <= '0;
    end else begin
      if (strobe.polWr) polReg <= polData;
      if (strobe.cfgWr) begin
        enReg  <= enData;
        dirReg <= dirData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  assign corrVec = syncB ^ polReg;

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    wakeSmiDebounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) deb_i (
      .clk     (clk),
      .rstN    (rstN),
      .levelIn (corrVec[p]),
      .levelOut(dbVec[p]),
      .riseNow (riseVec[p])
    );
    assign hitVec[p] = riseVec[p] && !dirReg[p] && (enReg[p] || altEnable[p]);
  end

  always_comb begin
    rdData = 8'h00;
    unique case (regAddr)
      ADDR_POL:  rdData[PIN_COUNT-1:0] = polReg;
      ADDR_CFG:  rdData = {1'b0, enReg, 1'b0, dirReg};
      ADDR_STAT: rdData[0] = statusBit;
      default:   rdData = 8'h00;
    endcase
  end

  logic unusedDbVec;
  assign unusedDbVec = ^dbVec;
endmodule

// File: rtl/wakeSmiTop.sv
module wakeSmiTop
  import wakeSmiPkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 31
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic [2:0] pinIn,
  input  logic [2:0] altEnable,
  output logic       smiReq
);
  ctrlStrobe_t          strobe;
  logic                 statusBit;
  logic [PIN_COUNT-1:0] hitVec;
  logic [PIN_COUNT-1:0] corrVec;
  logic                 unusedWrBits;

  assign unusedWrBits = regWrData[7] ^ regWrData[3];

  wakeSmiCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .clrBit   (regWrData[0]),
    .anyHit   (|hitVec),
    .strobe   (strobe),
    .statusBit(statusBit)
  );

  wakeSmiDatapath #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .polData  (regWrData[2:0]),
    .enData   (regWrData[6:4]),
    .dirData  (regWrData[2:0]),
    .pinIn    (pinIn),
    .altEnable(altEnable),
    .regAddr  (regAddr),
    .statusBit(statusBit),
    .rdData   (regRdData),
    .hitVec   (hitVec),
    .corrVec  (corrVec)
  );

  assign smiReq = statusBit;
endmodule

// File: rtl/wakeSmiChecker.sv
module wakeSmiChecker (
  input logic       clk,
  input logic       rstN,
  input logic       regWr,
  input logic [1:0] regAddr,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       smiReq,
  input logic [2:0] hitVec,
  input logic [2:0] corrVec
);
  logic clrWrite;
  assign clrWrite = regWr && (regAddr == 2'd2) && regWrData[0];

  // R10: an activation wins over a clear on the same edge
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|hitVec) |=> smiReq);

  // R9: a clearing write without a competing activation drops the flag
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && !(|hitVec)) |=> !smiReq);

  // R9: without a clearing write the flag holds
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (smiReq && !clrWrite) |=> smiReq);

  // R11: the flag rises only after an activation
  a_r11_rise_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(smiReq) |-> $past(|hitVec));

  // R12: the status read mirrors the request output
  a_r12_read_matches: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd2) |-> (regRdData == {7'b0, smiReq}));

  // R5: an activation needs a corrected level that was already active
  for (genvar p = 0; p < 3; p++) begin : g_chk
    a_r5_stable_before_hit: assert property (@(posedge clk) disable iff (!rstN)
      hitVec[p] |-> (corrVec[p] && $past(corrVec[p])));
  end
endmodule

bind wakeSmiTop wakeSmiChecker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .smiReq   (smiReq),
  .hitVec   (hitVec),
  .corrVec  (corrVec)
);

// File: tb/wakeSmiTop_tb_top.sv
module wakeSmiTop_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 31;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [2:0] pinIn = 3'b000;
  logic [2:0] altEnable = 3'b000;
  logic       smiReq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit modelLive = 1'b0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  wakeSmiTop #(.DEBOUNCE_CYCLES(DEB)) dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .altEnable(altEnable), .smiReq(smiReq)
  );

  // behavioural reference model
  bit mPol[3], mEn[3], mDir[3], mS1[3], mS2[3], mDb[3];
  int mCnt[3];
  bit mStatus;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin
        mPol[i] = 0; mEn[i] = 0; mDir[i] = 0;
        mS1[i] = 0; mS2[i] = 0; mDb[i] = 0; mCnt[i] = 0;
      end
      mStatus = 0;
      modelLive = 1'b1;
    end else begin
      bit hit;
      hit = 0;
      for (int i = 0; i < 3; i++) begin
        bit lvl;
        lvl = mS2[i] ^ mPol[i];
        if (lvl == mDb[i]) mCnt[i] = 0;
        else if (mCnt[i] + 1 >= DEB) begin
          mDb[i] = lvl;
          mCnt[i] = 0;
          if (lvl && !mDir[i] && (mEn[i] || altEnable[i])) hit = 1;
        end else mCnt[i] = mCnt[i] + 1;
      end
      for (int i = 0; i < 3; i++) begin
        mS2[i] = mS1[i];
        mS1[i] = pinIn[i];
      end
      if (hit) mStatus = 1;
      else if (regWr && regAddr == 2'd2 && regWrData[0]) mStatus = 0;
      if (regWr && regAddr == 2'd0)
        for (int i = 0; i < 3; i++) mPol[i] = regWrData[i];
      if (regWr && regAddr == 2'd1)
        for (int i = 0; i < 3; i++) begin
          mEn[i] = regWrData[4+i];
          mDir[i] = regWrData[i];
        end
    end
  end

  function automatic logic [7:0] modelRead(logic [1:0] a);
    logic [7:0] r;
    r = 8'h00;
    case (a)
      2'd0: r = {5'b0, mPol[2], mPol[1], mPol[0]};
      2'd1: r = {1'b0, mEn[2], mEn[1], mEn[0], 1'b0, mDir[2], mDir[1], mDir[0]};
      2'd2: r = {7'b0, mStatus};
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (modelLive && rstN && !done) begin
      chk({curReq, " model smiReq (R12)"}, smiReq, mStatus);
      chk({curReq, " model read"}, regRdData, modelRead(regAddr));
    end
  end

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    regWr = 1'b1; regAddr = a; regWrData = d;
    cyc(1);
    regWr = 1'b0; regWrData = 8'h00; regAddr = 2'd2;
  endtask

  task automatic rd(string req, logic [1:0] a, logic [7:0] exp);
    regAddr = a;
    #1;
    chk(req, regRdData, exp);
    regAddr = 2'd2;
    #1;
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);

    curReq = "R1";
    rd("R1 pol reset", 2'd0, 8'h00);
    rd("R1 cfg reset", 2'd1, 8'h00);
    rd("R1 stat reset", 2'd2, 8'h00);
    chk("R1 smiReq reset", smiReq, 0);

    curReq = "R2";
    wr(2'd0, 8'hFF);
    rd("R2 pol readback", 2'd0, 8'h07);
    wr(2'd0, 8'hA5);
    rd("R2 pol readback 2", 2'd0, 8'h05);
    wr(2'd0, 8'h00);
    cyc(DEB + 5);

    curReq = "R3";
    wr(2'd1, 8'hFF);
    rd("R3 cfg reserved zero", 2'd1, 8'h77);
    wr(2'd1, 8'h5A);
    rd("R3 cfg readback", 2'd1, 8'h52);
    wr(2'd1, 8'h00);
    rd("R12 addr3 zero", 2'd3, 8'h00);

    curReq = "R4";
    wr(2'd1, 8'h10);
    pinIn[0] = 1'b1;
    cyc(DEB + 1);
    chk("R4 not yet after DEB+1 edges", smiReq, 0);
    cyc(1);
    chk("R4 raised after DEB+2 edges", smiReq, 1);

    curReq = "R9";
    wr(2'd2, 8'hFE);
    chk("R9 write 0 keeps flag", smiReq, 1);
    wr(2'd2, 8'h01);
    chk("R9 write 1 clears flag", smiReq, 0);

    curReq = "R11";
    pinIn[0] = 1'b0;
    cyc(DEB + 8);
    chk("R11 release raises nothing", smiReq, 0);

    curReq = "R5";
    wr(2'd1, 8'h20);
    pinIn[1] = 1'b1;
    cyc(DEB - 4);
    pinIn[1] = 1'b0;
    cyc(6);
    pinIn[1] = 1'b1;
    cyc(DEB - 2);
    pinIn[1] = 1'b0;
    cyc(DEB + 8);
    chk("R5 short pulses ignored", smiReq, 0);

    curReq = "R6";
    pinIn[2] = 1'b1;
    cyc(DEB + 5);
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h40);
    cyc(DEB + 5);
    chk("R6 held high with active-low no event", smiReq, 0);
    pinIn[2] = 1'b0;
    cyc(DEB + 1);
    chk("R6 not yet", smiReq, 0);
    cyc(1);
    chk("R6 high-to-low raises", smiReq, 1);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    cyc(DEB + 5);
    chk("R6 cleanup", smiReq, 0);

    curReq = "R7";
    wr(2'd1, 8'h11);
    pinIn[0] = 1'b1;
    cyc(DEB + 8);
    chk("R7 output pin raises nothing", smiReq, 0);
    wr(2'd1, 8'h10);
    cyc(DEB + 5);
    chk("R7 already-active level not new", smiReq, 0);
    pinIn[0] = 1'b0;
    wr(2'd1, 8'h00);
    cyc(DEB + 5);

    curReq = "R8";
    altEnable[1] = 1'b1;
    pinIn[1] = 1'b1;
    cyc(DEB + 4);
    chk("R8 competing enable raises", smiReq, 1);
    wr(2'd2, 8'h01);
    pinIn[1] = 1'b0;
    altEnable[1] = 1'b0;
    cyc(DEB + 5);
    pinIn[1] = 1'b1;
    cyc(DEB + 6);
    chk("R8 no enable raises nothing", smiReq, 0);
    pinIn[1] = 1'b0;
    cyc(DEB + 5);

    curReq = "R10";
    wr(2'd1, 8'h10);
    altEnable[1] = 1'b1;
    pinIn[0] = 1'b1;
    cyc(DEB + 4);
    chk("R10 flag set first", smiReq, 1);
    pinIn[1] = 1'b1;
    cyc(DEB + 1);
    wr(2'd2, 8'h01);
    chk("R10 set wins over clear", smiReq, 1);
    wr(2'd2, 8'h01);
    chk("R10 later clear works", smiReq, 0);
    cyc(5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule